// File: doc/BRIEF.md
# Latched-Address One-of-Eight Selector

This block turns a small binary code into a one-hot group of select lines. The code first passes through an address hold stage. While the hold control is low the stage is transparent, and the outputs follow the live code in the same cycle. While the hold control is high the outputs decode a stored copy of the code. That copy is the code seen at the last rising clock edge at which the hold control was low. The stage lets a shared address bus move on while a previously chosen line stays selected.

Two enables gate the outputs. One is active high and the other active low. Decoding takes place only when both are in their active state. Otherwise every output rests at its inactive level. Because the gating is combinational and sits after the hold stage, the block can also act as a demultiplexer. Hold one enable active and drive a data bit onto the other. The data bit then appears on the addressed line only.

A parameter chooses whether the selected line is driven high or low. The inactive level is always the opposite one. The address width is a parameter, and the output count is derived from it.

Top module: `latched_sel_decoder`

## Requirements
- R1: With `hold` low, `en` high and `en_n` low, the output bit whose index equals the live `addr` value is active in the same cycle. Bit 0 of `addr` is the least significant bit, so code n selects `sel_out[n]`.
- R2: With `hold` high, the outputs decode the code that was sampled at the last rising edge of `clk` with `hold` low. Changes of `addr` while `hold` stays high do not move the outputs.
- R3: While `en_n` is high, every bit of `sel_out` is at its inactive level, regardless of `addr`, `hold` and `en`.
- R4: While `en` is low, every bit of `sel_out` is at its inactive level, regardless of `addr`, `hold` and `en_n`.
- R5: With `ACTIVE_LOW` = 0, the active level is 1 and the inactive level is 0. With `ACTIVE_LOW` = 1 both levels are inverted, and this includes the disabled state.
- R6: Disabling the outputs does not disturb the stored code. When both enables return to their active state with `hold` still high, the stored code is decoded again.
- R7: Demultiplexing: with `en_n` held low, the addressed output carries the value of `en`, in the block's active polarity, and all other outputs stay inactive. Likewise, with `en` held high, the addressed output carries the inverse of `en_n`.
- R8: Asynchronous reset (`rst_n` low) clears the stored code to 0. If `hold` is high from reset onward, the enabled outputs select line 0.
- R9: When both enables are active, exactly one output is at the active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the stored-code register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (3) | Binary select code, bit 0 least significant |
| hold | input | 1 | 1 = decode the stored code, 0 = transparent |
| en | input | 1 | Active-high output enable |
| en_n | input | 1 | Active-low output enable |
| sel_out | output | 2**ADDR_W (8) | One-hot select lines in the chosen polarity |

## Verification
The bench builds two copies side by side with the default 3-bit address. One has `ACTIVE_LOW` = 0 and the other `ACTIVE_LOW` = 1, and both share the same stimulus. Every expected vector is therefore checked in both polarities, including the inactive level during disable. This exposes a polarity slip that a single build would not show. Under transparency the stimulus sweeps every code against every enable pair. It then stores each code in turn and scrambles the address while holding. After that it toggles each enable as a data line, and it ends with a long seeded random mix compared against a bench model of the stored code.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
   localparam int unsigned LDEC_MAX_ADDR_W = 6;

   function automatic bit ldec_addr_w_ok(input int unsigned w);
      return (w >= 1) && (w <= LDEC_MAX_ADDR_W);
   endfunction

   function automatic bit ldec_pol_ok(input int unsigned p);
      return (p == 0) || (p == 1);
   endfunction
endpackage

// File: rtl/lsd_addr_hold.sv
module lsd_addr_hold #(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_eff
);
   logic [ADDR_W-1:0] stored_q;

   // the stored copy tracks the live code on every edge while transparent
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q <= '0;
      end else if (!hold) begin
         stored_q <= addr_in;
      end
   end

   assign addr_eff = hold ? stored_q : addr_in;
endmodule

// File: rtl/lsd_onehot.sv
module lsd_onehot #(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned NUM_OUT = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]  code,
   output logic [NUM_OUT-1:0] hot
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
      assign hot[i] = (code == ADDR_W'(i));
   end
endmodule

// File: rtl/lsd_out_gate.sv
module lsd_out_gate #(
   parameter int unsigned NUM_OUT    = 8,
   parameter int unsigned ACTIVE_LOW = 0
) (
   input  logic               en,
   input  logic               en_n,
   input  logic [NUM_OUT-1:0] hot,
   output logic [NUM_OUT-1:0] sel_out
);
   logic               pass;
   logic [NUM_OUT-1:0] gated;

   assign pass  = en & ~en_n;
   assign gated = hot & {NUM_OUT{pass}};

   if (ACTIVE_LOW != 0) begin : g_pol_low
      assign sel_out = ~gated;
   end else begin : g_pol_high
      assign sel_out = gated;
   end
endmodule

// File: rtl/latched_sel_decoder.sv
module latched_sel_decoder #(
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned ACTIVE_LOW = 0,
   localparam int unsigned NUM_OUT   = 1 << ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               hold,
   input  logic               en,
   input  logic               en_n,
   output logic [NUM_OUT-1:0] sel_out
);
   import ldec_pkg::*;

   if (!ldec_addr_w_ok(ADDR_W)) begin : g_bad_w
      $error("latched_sel_decoder: ADDR_W out of range");
   end
   if (!ldec_pol_ok(ACTIVE_LOW)) begin : g_bad_pol
      $error("latched_sel_decoder: ACTIVE_LOW must be 0 or 1");
   end

   logic [ADDR_W-1:0]  code_eff;
   logic [NUM_OUT-1:0] hot;

   lsd_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .addr_in  (addr),
      .addr_eff (code_eff)
   );

   lsd_onehot #(.ADDR_W(ADDR_W)) u_dec (
      .code (code_eff),
      .hot  (hot)
   );

   lsd_out_gate #(.NUM_OUT(NUM_OUT), .ACTIVE_LOW(ACTIVE_LOW)) u_gate (
      .en      (en),
      .en_n    (en_n),
      .hot     (hot),
      .sel_out (sel_out)
   );
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned ACTIVE_LOW = 0,
   localparam int unsigned NUM_OUT   = 1 << ADDR_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr,
   input logic               hold,
   input logic               en,
   input logic               en_n,
   input logic [NUM_OUT-1:0] sel_out
);
   logic [NUM_OUT-1:0] act;
   logic               on;
   assign act = (ACTIVE_LOW != 0) ? ~sel_out : sel_out;
   assign on  = en && !en_n;

   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!on) |-> (act == '0)); // R3
   AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) on |-> ($countones(act) == 1)); // R9
   AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n) (on && !hold) |-> act[addr]); // R1
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (hold && $past(hold) && on && $past(on)) |-> $stable(sel_out)); // R2
   AST_DEMUX_LINE: assert property (@(posedge clk) disable iff (!rst_n) (!en_n && !hold) |-> (act[addr] == en)); // R7
endmodule

bind latched_sel_decoder lsd_checker #(.ADDR_W(ADDR_W), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .hold    (hold),
   .en      (en),
   .en_n    (en_n),
   .sel_out (sel_out)
);

// File: tb/latched_sel_decoder_tb_top.sv
module latched_sel_decoder_tb_top;
   localparam int AW = 3;
   localparam int NO = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          hold, en, en_n;
   logic [NO-1:0] sel_hi, sel_lo;
   logic [AW-1:0] m_held;
   int            checks = 0;
   int            failures = 0;
   bit            done = 0;

   always #4 clk = ~clk;

   latched_sel_decoder #(.ADDR_W(AW), .ACTIVE_LOW(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .hold(hold),
      .en(en), .en_n(en_n), .sel_out(sel_hi));

   latched_sel_decoder #(.ADDR_W(AW), .ACTIVE_LOW(1)) dut_lo_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .hold(hold),
      .en(en), .en_n(en_n), .sel_out(sel_lo));

   // bench model of the stored code, from R2 and R8
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)    m_held <= '0;
      else if (!hold) m_held <= addr;
   end

   function automatic logic [NO-1:0] expect_vec(input logic [AW-1:0] a,
         input logic e, input logic en_bar, input bit low_pol);
      logic [NO-1:0] v;
      v = (e && !en_bar) ? (NO'(1) << a) : '0;
      return low_pol ? ~v : v;
   endfunction

   task automatic check(input string req);
      logic [AW-1:0] a;
      logic [NO-1:0] eh, el;
      a  = hold ? m_held : addr;
      eh = expect_vec(a, en, en_n, 0);
      el = expect_vec(a, en, en_n, 1);
      checks += 2;
      if (sel_hi !== eh) begin
         failures++;
         $display("FAIL %s high-pol: actual=%b expected=%b", req, sel_hi, eh);
      end
      if (sel_lo !== el) begin
         failures++;
         $display("FAIL %s low-pol: actual=%b expected=%b", req, sel_lo, el);
      end
   endtask

   // drive on the falling edge, sample 1 ns later
   task automatic drive(input logic [AW-1:0] a, input logic h, input logic e, input logic eb);
      @(negedge clk);
      addr = a; hold = h; en = e; en_n = eb;
      #1;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      rst_n = 1'b0; addr = 3'd5; hold = 1'b1; en = 1'b1; en_n = 1'b0;
      #1;
      check("R8 in reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive(3'd6, 1'b1, 1'b1, 1'b0);
      check("R8 after reset");

      // R1 R3 R4 R5 R9: every code against every enable pair, transparent
      for (int a = 0; a < NO; a++) begin
         for (int k = 0; k < 4; k++) begin
            drive(AW'(a), 1'b0, k[0], k[1]);
            check("R1/R3/R4/R5/R9 sweep");
         end
      end

      // R2: store each code, then scramble the address
      for (int a = 0; a < NO; a++) begin
         drive(AW'(a), 1'b0, 1'b1, 1'b0);
         drive(AW'($urandom_range(NO - 1)), 1'b1, 1'b1, 1'b0);
         check("R2 hold entry");
         for (int j = 0; j < 5; j++) begin
            drive(AW'($urandom_range(NO - 1)), 1'b1, 1'b1, 1'b0);
            check("R2 hold scramble");
         end
      end

      // R6: disable during hold, then re-enable
      drive(3'd3, 1'b0, 1'b1, 1'b0);
      drive(3'd7, 1'b1, 1'b0, 1'b0);
      check("R6 disabled by en");
      drive(3'd1, 1'b1, 1'b1, 1'b1);
      check("R6 disabled by en_n");
      drive(3'd0, 1'b1, 1'b1, 1'b0);
      check("R6 resume held");

      // R7: demultiplex with each enable as data
      for (int j = 0; j < 16; j++) begin
         drive(AW'($urandom_range(NO - 1)), 1'b0, 1'($urandom_range(1)), 1'b0);
         check("R7 data on en");
      end
      for (int j = 0; j < 16; j++) begin
         drive(AW'($urandom_range(NO - 1)), 1'b0, 1'b1, 1'($urandom_range(1)));
         check("R7 data on en_n");
      end

      // random mix against the model
      for (int j = 0; j < 400; j++) begin
         drive(AW'($urandom_range(NO - 1)), 1'($urandom_range(3) != 0),
               1'($urandom_range(3) != 0), 1'($urandom_range(3) == 0));
         check("R1/R2/R3/R4 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule